// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

The block counts activity on one external input pin with a single 8-bit counter. A mode input picks how the counter advances. In event mode it steps once for each chosen transition of the pin, rising or falling. In gated mode it steps on a slow internal tick while the pin sits at the chosen level. The slow tick is the system clock-enable input divided by 64. The pin is asynchronous, so it passes through a two-stage synchronizer before any edge or level decision is made.

A small state machine follows the enable, the mode and the synchronized pin level. It has four states. ST_HOLD means the block is disabled. ST_EVENT means event counting. ST_GATE_WAIT means gated mode with the gate closed. ST_GATE_RUN means gated mode with the gate open. On every clock the next state depends only on the inputs:
- enable low goes to ST_HOLD;
- enable high with event mode goes to ST_EVENT;
- enable high with gated mode goes to ST_GATE_RUN if the synchronized level is active, and to ST_GATE_WAIT if it is not.

So the named transitions are:
- any state to ST_HOLD on disable;
- ST_HOLD or a gated state to ST_EVENT;
- ST_HOLD or ST_EVENT into either gated state;
- ST_GATE_WAIT to ST_GATE_RUN when the gate opens;
- ST_GATE_RUN to ST_GATE_WAIT when the gate closes. This is the trailing edge, and it raises the edge flag.

Software can load the counter only while the block is disabled. It can clear each of the two sticky flags at any time.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count is 0, both flags are 0, the state machine is in ST_HOLD and the tick divider is at 0.
- R2: The pin is synchronized by two flops. A pin change driven just after a clock edge can first change the count at the third following clock edge.
- R3: In ST_EVENT, while enable is high and mode_gated=0, the count steps by one for each active edge of the synchronized pin. The active edge is rising when pol_sel=0 and falling when pol_sel=1. A change of pol_sel alone is not an edge.
- R4: Each counted event-mode edge sets edge_flag.
- R5: In ST_GATE_RUN, while enable is high and mode_gated=1, the count steps by one on every 64th tick_en pulse. The gate is open while the synchronized pin is high (pol_sel=0) or low (pol_sel=1). At all other times the count does not advance.
- R6: In gated mode, the move from ST_GATE_RUN to ST_GATE_WAIT (the trailing edge of the active level) sets edge_flag.
- R7: A step from 0xFF wraps the count to 0x00 and sets ovf_flag. ovf_flag stays set until sw_clr_ovf=1; a set in the same cycle takes priority over the clear. edge_flag is cleared by sw_clr_edge with the same priority rule.
- R8: While acc_en=0 the count holds and no flag is set.
- R9: With acc_en=0, sw_wr=1 loads sw_wdata into the count at the next edge. With acc_en=1, sw_wr is ignored.
- R10: The tick divider counts every tick_en pulse from reset, whatever the enable and mode. The 64th, 128th and so on pulse is the gated tick.
- R11: The state follows the next-state rule given above, so the first cycle after enable rises never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accumulator enable |
| mode_gated | input | 1 | 0 = event counting, 1 = gated time accumulation |
| pol_sel | input | 1 | 0 = rising edge / high level, 1 = falling edge / low level |
| pin_in | input | 1 | Asynchronous external input |
| tick_en | input | 1 | System clock-enable pulse feeding the divide-by-64 |
| sw_wr | input | 1 | Load count from sw_wdata (disabled only) |
| sw_wdata | input | 8 | Count load value |
| sw_clr_ovf | input | 1 | Clear overflow flag |
| sw_clr_edge | input | 1 | Clear edge flag |
| count | output | 8 | Accumulator value |
| ovf_flag | output | 1 | Sticky wrap flag |
| edge_flag | output | 1 | Sticky input-edge flag |

## Verification
The assertions check, on every cycle, the counter rules that are local:
- the count holds while disabled;
- a load takes the written value;
- the count only ever steps by one or wraps;
- a wrap raises the overflow flag;
- both flags stay set until cleared;
- disabling the block forces ST_HOLD.

Some properties need the relationship between the pin, the synchronizer and the tick divider, so only the bench scenarios can show them:
- whether an edge is counted, and with which polarity;
- the two-cycle synchronizer latency;
- the rate of the gated count;
- the trailing-edge flag;
- the rule that a load is ignored while enabled.

// File: rtl/pa_pkg.sv
package pa_pkg;
    typedef enum logic [1:0] {
        ST_HOLD      = 2'd0,
        ST_EVENT     = 2'd1,
        ST_GATE_WAIT = 2'd2,
        ST_GATE_RUN  = 2'd3
    } pa_state_e;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic lvl_d
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    // one more flop keeps the previous synchronized value for edge decisions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign lvl   = chain_q[STAGES-1];
    assign lvl_d = prev_q;

    AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl_d == $past(lvl))); // R2
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic tick_out
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (tick_en) begin
            if (div_q == LAST) div_q <= '0;
            else               div_q <= div_q + 1'b1;
        end
    end

    assign tick_out = tick_en && (div_q == LAST);

    AST_DIV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(div_q)); // R10
endmodule

// File: rtl/pa_fsm.sv
module pa_fsm
    import pa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode_gated,
    input  logic pol_sel,
    input  logic lvl,
    input  logic lvl_d,
    input  logic tick,
    output logic step,
    output logic edge_set
);
    pa_state_e state_q, state_d;
    logic      act_now, act_prev;

    assign act_now  = lvl ^ pol_sel;
    assign act_prev = lvl_d ^ pol_sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        if (!en)             state_d = ST_HOLD;
        else if (!mode_gated) state_d = ST_EVENT;
        else if (act_now)    state_d = ST_GATE_RUN;
        else                 state_d = ST_GATE_WAIT;
    end

    always_comb begin
        step     = 1'b0;
        edge_set = 1'b0;
        unique case (state_q)
            ST_HOLD: begin
                step     = 1'b0;
                edge_set = 1'b0;
            end
            ST_EVENT: begin
                if (en && !mode_gated && act_now && !act_prev) begin
                    step     = 1'b1;
                    edge_set = 1'b1;
                end
            end
            ST_GATE_WAIT: begin
                step     = 1'b0;
                edge_set = 1'b0;
            end
            ST_GATE_RUN: begin
                if (en && mode_gated) begin
                    step     = tick;
                    edge_set = !act_now;
                end
            end
            default: begin
                step     = 1'b0;
                edge_set = 1'b0;
            end
        endcase
    end

    AST_OFF_TO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_HOLD)); // R11
    AST_NO_STEP_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> !step); // R11
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          step,
    input  logic          edge_set,
    input  logic          sw_wr,
    input  logic [CW-1:0] sw_wdata,
    input  logic          sw_clr_ovf,
    input  logic          sw_clr_edge,
    output logic [CW-1:0] cnt,
    output logic          ovf,
    output logic          edg
);
    localparam logic [CW-1:0] TOP = '1;

    logic load;
    assign load = sw_wr && !en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= sw_wdata;
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (step && (cnt == TOP)) begin
            ovf <= 1'b1;
        end else if (sw_clr_ovf) begin
            ovf <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edg <= 1'b0;
        end else if (edge_set) begin
            edg <= 1'b1;
        end else if (sw_clr_edge) begin
            edg <= 1'b0;
        end
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !sw_wr) |=> $stable(cnt)); // R8
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && sw_wr) |=> (cnt == $past(sw_wdata))); // R9
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1))); // R3
    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == TOP) |=> ((cnt == TOP) || ovf)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !sw_clr_ovf) |=> ovf); // R7
    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (edg && !sw_clr_edge) |=> edg); // R7
endmodule

// File: rtl/pulse_accum.sv
module pulse_accum #(
    parameter int CW          = 8,
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          mode_gated,
    input  logic          pol_sel,
    input  logic          pin_in,
    input  logic          tick_en,
    input  logic          sw_wr,
    input  logic [CW-1:0] sw_wdata,
    input  logic          sw_clr_ovf,
    input  logic          sw_clr_edge,
    output logic [CW-1:0] count,
    output logic          ovf_flag,
    output logic          edge_flag
);
    logic lvl, lvl_d, tick, step, edge_set;

    pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .lvl   (lvl),
        .lvl_d (lvl_d)
    );

    pa_prescale #(.DIV(DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .tick_out (tick)
    );

    pa_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (acc_en),
        .mode_gated (mode_gated),
        .pol_sel    (pol_sel),
        .lvl        (lvl),
        .lvl_d      (lvl_d),
        .tick       (tick),
        .step       (step),
        .edge_set   (edge_set)
    );

    pa_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (acc_en),
        .step        (step),
        .edge_set    (edge_set),
        .sw_wr       (sw_wr),
        .sw_wdata    (sw_wdata),
        .sw_clr_ovf  (sw_clr_ovf),
        .sw_clr_edge (sw_clr_edge),
        .cnt         (count),
        .ovf         (ovf_flag),
        .edg         (edge_flag)
    );

    AST_FLAGS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en && !ovf_flag) |=> !ovf_flag); // R8
endmodule

// File: tb/pulse_accum_tb.sv
module pulse_accum_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0, mode_gated = 1'b0, pol_sel = 1'b0, pin_in = 1'b0;
    logic       tick_en = 1'b0, sw_wr = 1'b0, sw_clr_ovf = 1'b0, sw_clr_edge = 1'b0;
    logic [7:0] sw_wdata = 8'h00;
    logic [7:0] count;
    logic       ovf_flag, edge_flag;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk; // 125 MHz

    pulse_accum u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .mode_gated(mode_gated),
        .pol_sel(pol_sel), .pin_in(pin_in), .tick_en(tick_en), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .sw_clr_ovf(sw_clr_ovf), .sw_clr_edge(sw_clr_edge),
        .count(count), .ovf_flag(ovf_flag), .edge_flag(edge_flag)
    );

    // behavioural reference: 0 hold, 1 event, 2 gate closed, 3 gate open
    bit m_s1, m_s2, m_s3, m_ovf, m_edge;
    int m_cnt, m_pre, m_st;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_ovf = 0; m_edge = 0;
            m_cnt = 0; m_pre = 0; m_st = 0;
        end else begin
            bit an, ap, tk, ev, gi, tr, inc;
            an = m_s2 ^ pol_sel;
            ap = m_s3 ^ pol_sel;
            tk = tick_en && (m_pre == 63);
            ev = acc_en && !mode_gated && (m_st == 1) && an && !ap;
            gi = acc_en && mode_gated && (m_st == 3) && tk;
            tr = acc_en && mode_gated && (m_st == 3) && !an;
            inc = ev || gi;
            if (inc && m_cnt == 255) m_ovf = 1; else if (sw_clr_ovf) m_ovf = 0;
            if (ev || tr) m_edge = 1; else if (sw_clr_edge) m_edge = 0;
            if (!acc_en && sw_wr) m_cnt = sw_wdata;
            else if (inc) m_cnt = (m_cnt + 1) % 256;
            if (!acc_en) m_st = 0; else if (!mode_gated) m_st = 1; else m_st = an ? 3 : 2;
            if (tick_en) m_pre = (m_pre + 1) % 64;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            n_chk++;
            if (count != m_cnt[7:0]) begin
                n_bad++;
                $display("FAIL %s count actual=%0d expected=%0d t=%0t", cur_req, count, m_cnt, $time);
            end
            n_chk++;
            if (ovf_flag != m_ovf) begin
                n_bad++;
                $display("FAIL R7 ovf_flag actual=%0d expected=%0d t=%0t", ovf_flag, m_ovf, $time);
            end
            n_chk++;
            if (edge_flag != m_edge) begin
                n_bad++;
                $display("FAIL %s edge_flag actual=%0d expected=%0d t=%0t",
                         mode_gated ? "R6" : "R4", edge_flag, m_edge, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_pin(input int n);
        for (int i = 0; i < n; i++) begin
            pin_in = 1'b1; step(4);
            pin_in = 1'b0; step(4);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int v;
        step(3);
        // R1 reset state
        cur_req = "R1";
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 edge", edge_flag, 0);
        rst_n = 1'b1;
        step(2);

        // R11 enable on, R3 rising edges, R4 flag
        cur_req = "R3";
        acc_en = 1'b1; step(2);
        pulse_pin(5); step(4);
        chk("R3 rising count", count, 5);
        chk("R4 edge flag", edge_flag, 1);
        sw_clr_edge = 1'b1; step(1); sw_clr_edge = 1'b0; step(1);
        chk("R7 edge cleared", edge_flag, 0);

        // R2 latency: count changes at the third edge after the pin change
        cur_req = "R2";
        pin_in = 1'b1; step(2);
        chk("R2 not yet", count, 5);
        step(1);
        chk("R2 counted", count, 6);
        pin_in = 1'b0; step(4);

        // R3 falling edges with pol_sel=1; polarity change alone is no edge
        cur_req = "R3";
        pol_sel = 1'b1; step(4);
        chk("R3 pol change no edge", count, 6);
        pulse_pin(3); step(4);
        chk("R3 falling count", count, 9);

        // R8 hold while disabled, R9 load
        cur_req = "R8";
        acc_en = 1'b0; sw_clr_edge = 1'b1; step(1); sw_clr_edge = 1'b0;
        pulse_pin(3); step(4);
        chk("R8 hold count", count, 9);
        chk("R8 no flag", edge_flag, 0);
        cur_req = "R9";
        sw_wdata = 8'hFD; sw_wr = 1'b1; step(1); sw_wr = 1'b0; step(1);
        chk("R9 load", count, 253);
        acc_en = 1'b1; sw_wdata = 8'h11; sw_wr = 1'b1; step(1); sw_wr = 1'b0; step(2);
        chk("R9 ignored while enabled", count, 253);

        // R7 wrap and sticky overflow
        cur_req = "R7";
        pol_sel = 1'b0; step(4);
        pulse_pin(3); step(4);
        chk("R7 wrapped", count, 0);
        chk("R7 ovf set", ovf_flag, 1);
        step(20);
        chk("R7 ovf sticky", ovf_flag, 1);
        sw_clr_ovf = 1'b1; step(1); sw_clr_ovf = 1'b0; step(1);
        chk("R7 ovf cleared", ovf_flag, 0);

        // R5 gated high level, R10 free-running divider, R6 trailing flag
        cur_req = "R5";
        acc_en = 1'b0; sw_wdata = 8'h00; sw_wr = 1'b1; sw_clr_edge = 1'b1;
        step(1); sw_wr = 1'b0; sw_clr_edge = 1'b0;
        tick_en = 1'b1; mode_gated = 1'b1; acc_en = 1'b1; step(2);
        pin_in = 1'b1; step(640);
        v = count;
        chk("R5 gated rate", (v >= 9 && v <= 11) ? 1 : 0, 1);
        chk("R6 no flag while open", edge_flag, 0);
        cur_req = "R6";
        pin_in = 1'b0; step(4);
        chk("R6 trailing flag", edge_flag, 1);
        cur_req = "R5";
        step(200);
        chk("R5 closed gate holds", count, v);

        // R5 gated low level with pol_sel=1
        pol_sel = 1'b1; step(320);
        v = count;
        chk("R5 low-level gate counts", (v >= 14 && v <= 16) ? 1 : 0, 1);
        pol_sel = 1'b0;

        // R10 R11 random mix, model compares every clock
        cur_req = "R11";
        for (int i = 0; i < 6000; i++) begin
            v = $urandom;
            pin_in      = v[0] ^ v[1];
            tick_en     = v[2] | v[3];
            acc_en      = (v[7:4] != 4'h0);
            mode_gated  = (i / 700) % 2 == 1;
            pol_sel     = (i / 1100) % 2 == 1;
            sw_wr       = (v[11:8] == 4'h0);
            sw_wdata    = v[23:16];
            sw_clr_ovf  = (v[15:12] == 4'h0);
            sw_clr_edge = (v[27:24] == 4'h0);
            step(1);
        end
        sw_wr = 1'b0; sw_clr_ovf = 1'b0; sw_clr_edge = 1'b0;
        step(4);
        finish_run();
    end
endmodule